// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Engine

This block models the write path of a byte-wide nonvolatile memory that sits on an SRAM-style bus with active-low chip enable, output enable and write enable and a shared bidirectional 8-bit data bus. The host stores bytes with ordinary write strobes. Each accepted byte is held in a 64-entry page buffer, together with a per-byte loaded flag, so the host bus is free again as soon as the strobe ends.

When no further accepted strobe has arrived for `IDLE_CYC` clock cycles, a self-timed commit copies the loaded bytes of that page into the storage array, one byte per cycle. The commit always lasts `COMMIT_CYC` cycles. From the first accepted write until the commit ends, the block is busy. During that time a read returns a status byte instead of stored data. Bit 7 of that byte is the inverse of bit 7 of the most recent byte written, and bit 6 flips on every read. Once the block is idle, reads return array contents again.

The array size is set by `ADDR_W`. The full-size part uses 13 address bits and 8192 bytes. The default here is 11 bits to keep elaboration small. Address bit 0 to bit 5 select the byte in a page, and the bits above them select the page.

Top module: `pageWriteEeprom`

## Requirements
- R1: After reset `busy` is low and the block does not drive the data bus.
- R2: The block drives `dataIo` only while `ceN` and `oeN` are both low and `weN` is high; in every other combination the bus is left undriven.
- R3: A write strobe starts when `ceN` and `weN` are both low after not having been both low. While idle, such a strobe is accepted, and `busy` is high from the next clock cycle on.
- R4: After the commit, each byte loaded in the page holds its written value in the array. Every other byte of that page keeps its earlier array value.
- R5: During loading, a write whose page bits (`addr[ADDR_W-1:6]`) differ from those of the first accepted byte is ignored, and the array is left unchanged at that address.
- R6: `busy` falls exactly `IDLE_CYC + COMMIT_CYC` clock edges after the edge that accepted the last byte of the page.
- R7: A write that arrives after loading has ended and the commit has started is ignored. The committed data and the array are unchanged by it.
- R8: A read while `busy` is high returns the inverse of bit 7 of the last accepted byte on bit 7, and zero on bits 5 to 0.
- R9: While `busy` is high, bit 6 of the read data differs between two consecutive read accesses, and it is steady for the rest of one read access.
- R10: If the same byte offset is written more than once in one loading phase, the value from the last write is the one committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; bits 5..0 select the offset, the upper bits select the page |
| dataIo | inout | 8 | Bidirectional data bus |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| busy | output | 1 | High from the first accepted write until the commit ends |

## Verification
A wrong loaded-flag or page-buffer entry stays hidden until the commit ends. It then shows on the next normal read of that page as a wrong byte, either a loaded byte that is missing or an unloaded byte that was overwritten. The bench therefore reads back every byte of the page after each write cycle. A wrong commit counter shows at once as a `busy` fall time that is off by some cycles from the accepting edge. A wrong toggle or polling register shows on the very next read while busy, one or two cycles after the read begins.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int unsigned PAGE_BYTES = 64;
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } pweState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               capture;    // take addr/data into the page buffer
    logic               commitWr;   // copy one buffered byte into the array
    logic               clearMask;  // forget loaded flags at commit end
    logic               rdStart;    // first cycle of a read access
    logic [PAGE_AW-1:0] idx;        // byte offset being committed
  } pweStrobes_t;
endpackage

// File: rtl/pweCtrl.sv
module pweCtrl
  import pwe_pkg::*;
#(
  parameter int unsigned PAGE_W     = 5,
  parameter int unsigned IDLE_CYC   = 25000,
  parameter int unsigned COMMIT_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [PAGE_W-1:0] reqPage,
  output pweStrobes_t       strb,
  output logic [PAGE_W-1:0] curPage,
  output logic              busy
);
  localparam int unsigned COMMIT_EFF = (COMMIT_CYC < PAGE_BYTES) ? PAGE_BYTES : COMMIT_CYC;
  localparam int unsigned IDLE_EFF   = (IDLE_CYC < 1) ? 1 : IDLE_CYC;
  localparam int unsigned CNT_MAX    = (COMMIT_EFF > IDLE_EFF) ? COMMIT_EFF : IDLE_EFF;
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

  pweState_e        state;
  logic [CNT_W-1:0] cnt;
  logic             wrActQ;
  logic             rdActQ;
  logic             wrAct;
  logic             rdAct;
  logic             wrStart;
  logic             samePage;
  logic             idleDone;
  logic             commitDone;

  assign wrAct      = ~ceN & ~weN;
  assign rdAct      = ~ceN & ~oeN & weN;
  assign wrStart    = wrAct & ~wrActQ;
  assign samePage   = (reqPage == curPage);
  assign idleDone   = (cnt == CNT_W'(IDLE_EFF - 1));
  assign commitDone = (cnt == CNT_W'(COMMIT_EFF - 1));
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strb           = '0;
    strb.rdStart   = rdAct & ~rdActQ;
    strb.idx       = cnt[PAGE_AW-1:0];
    unique case (state)
      ST_IDLE:   strb.capture   = wrStart;
      ST_LOAD:   strb.capture   = wrStart & samePage;
      ST_COMMIT: begin
        strb.commitWr  = (cnt < CNT_W'(PAGE_BYTES));
        strb.clearMask = commitDone;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      rdActQ <= 1'b0;
    end else begin
      wrActQ <= wrAct;
      rdActQ <= rdAct;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      curPage <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wrStart) begin
            state   <= ST_LOAD;
            curPage <= reqPage;
            cnt     <= '0;
          end
        end
        ST_LOAD: begin
          if (wrStart && samePage) begin
            cnt <= '0;
          end else if (idleDone) begin
            state <= ST_COMMIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (commitDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pweDatapath.sv
module pweDatapath
  import pwe_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pweStrobes_t               strb,
  input  logic                      busy,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-PAGE_AW-1:0] curPage,
  input  logic [7:0]                wrData,
  output logic [7:0]                rdData
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0]            mem       [DEPTH];
  logic [7:0]            pageBuf   [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic                  lastBit7;
  logic                  toggleQ;
  logic [PAGE_AW-1:0]    wrOfs;
  logic [7:0]            statusByte;
  logic [ADDR_W-1:0]     commitAddr;

  assign wrOfs      = addr[PAGE_AW-1:0];
  assign statusByte = {~lastBit7, toggleQ, 6'b0};
  assign commitAddr = {curPage, strb.idx};

  always_ff @(posedge clk) begin
    if (strb.capture) pageBuf[wrOfs] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded   <= '0;
      lastBit7 <= 1'b0;
      toggleQ  <= 1'b0;
    end else begin
      if (strb.clearMask) loaded <= '0;
      else if (strb.capture) loaded[wrOfs] <= 1'b1;
      if (strb.capture) lastBit7 <= wrData[7];
      if (strb.rdStart && busy) toggleQ <= ~toggleQ;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commitWr && loaded[strb.idx]) mem[commitAddr] <= pageBuf[strb.idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= busy ? statusByte : mem[addr];
  end
endmodule

// File: rtl/pageWriteEeprom.sv
module pageWriteEeprom
  import pwe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned IDLE_CYC   = 25000,
  parameter int unsigned COMMIT_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [7:0]        dataIo,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  output logic              busy
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_AW;

  pweStrobes_t       strb;
  logic [PAGE_W-1:0] curPage;
  logic [7:0]        rdData;
  logic              driveEn;

  assign driveEn = ~ceN & ~oeN & weN;
  assign dataIo  = driveEn ? rdData : 8'bz;

  pweCtrl #(
    .PAGE_W    (PAGE_W),
    .IDLE_CYC  (IDLE_CYC),
    .COMMIT_CYC(COMMIT_CYC)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .oeN    (oeN),
    .weN    (weN),
    .reqPage(addr[ADDR_W-1:PAGE_AW]),
    .strb   (strb),
    .curPage(curPage),
    .busy   (busy)
  );

  pweDatapath #(
    .ADDR_W(ADDR_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .busy   (busy),
    .addr   (addr),
    .curPage(curPage),
    .wrData (dataIo),
    .rdData (rdData)
  );
endmodule

// File: rtl/pweChecker.sv
module pweChecker #(
  parameter int unsigned IDLE_CYC   = 25000,
  parameter int unsigned COMMIT_CYC = 2500000
) (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       oeN,
  input logic       weN,
  input logic [7:0] dataIo,
  input logic       busy
);
  localparam int unsigned COMMIT_EFF = (COMMIT_CYC < 64) ? 64 : COMMIT_CYC;
  localparam int unsigned IDLE_EFF   = (IDLE_CYC < 1) ? 1 : IDLE_CYC;
  localparam int unsigned LIMIT      = IDLE_EFF + COMMIT_EFF;

  logic        wrSeen;
  logic [31:0] sinceWr;
  logic        rdAct;

  assign rdAct = ~ceN & ~oeN & weN;

  // independent cycle counter since the most recent write strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeen  <= 1'b0;
      sinceWr <= '0;
    end else begin
      wrSeen <= ~ceN & ~weN;
      if ((~ceN & ~weN) && !wrSeen) sinceWr <= '0;
      else if (sinceWr != 32'hFFFF_FFFF) sinceWr <= sinceWr + 1'b1;
    end
  end

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(~ceN & ~weN));

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (sinceWr <= LIMIT));

  p_status_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && rdAct && $past(rdAct)) |-> (dataIo[5:0] == 6'b0));

  p_toggle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(busy, 2) && $past(busy, 3) &&
     rdAct && $past(rdAct) && $past(rdAct, 2) && $past(rdAct, 3)) |-> $stable(dataIo[6]));
endmodule

bind pageWriteEeprom pweChecker #(
  .IDLE_CYC  (IDLE_CYC),
  .COMMIT_CYC(COMMIT_CYC)
) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .ceN   (ceN),
  .oeN   (oeN),
  .weN   (weN),
  .dataIo(dataIo),
  .busy  (busy)
);

// File: tb/tb_pageWriteEeprom.sv
`timescale 1ns/1ps
module tb_pageWriteEeprom;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned IDLE_CYC   = 12;
  localparam int unsigned COMMIT_CYC = 80;
  localparam int unsigned DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ceN = 1'b1;
  logic              oeN = 1'b1;
  logic              weN = 1'b1;
  logic              drvEn = 1'b0;
  logic [7:0]        drvData = '0;
  logic              busy;
  tri1  [7:0]        dataIo;

  assign dataIo = drvEn ? drvData : 8'bz;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] lastByte;

  always #2 clk = ~clk;

  pageWriteEeprom #(
    .ADDR_W    (ADDR_W),
    .IDLE_CYC  (IDLE_CYC),
    .COMMIT_CYC(COMMIT_CYC)
  ) dut (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .dataIo(dataIo),
    .ceN   (ceN),
    .oeN   (oeN),
    .weN   (weN),
    .busy  (busy)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(int page, int ofs);
    return ADDR_W'((page << 6) | (ofs & 63));
  endfunction

  function automatic logic [7:0] expPollBits(logic [7:0] last);
    return {~last[7], 7'b0};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeByte(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; drvData = d; drvEn = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1; drvEn = 1'b0;
  endtask

  task automatic readByte(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    repeat (2) @(negedge clk);
    d = dataIo;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic checkPage(int page, string req);
    logic [7:0] r;
    for (int o = 0; o < 64; o++) begin
      readByte(mkAddr(page, o), r);
      chk(req, r, model[mkAddr(page, o)]);
    end
  endtask

  task automatic fillPage(int page);
    for (int o = 0; o < 64; o++) begin
      logic [7:0] d;
      d = 8'($urandom);
      writeByte(mkAddr(page, o), d);
      model[mkAddr(page, o)] = d;
    end
    waitIdle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] r1;
    logic [7:0] r2;
    logic [7:0] d;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1: reset state, bus floats to the pull-up value
    chk("R1 busy", busy, 0);
    chk("R1 bus", dataIo, 8'hFF);
    rstN = 1'b1;
    @(negedge clk);

    // R4: full pages as the known baseline
    fillPage(3);
    fillPage(5);
    checkPage(3, "R4 full page");
    checkPage(5, "R4 full page");

    // R2: bus drive conditions
    addr = mkAddr(3, 0);
    model[mkAddr(3, 0)] = model[mkAddr(3, 0)];
    @(negedge clk); ceN = 1'b0; oeN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 oe high", dataIo, 8'hFF);
    ceN = 1'b1; oeN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 ce high", dataIo, 8'hFF);
    oeN = 1'b1;

    // R3, R6: exact busy window after a single byte, R8/R9 polling
    d = (model[mkAddr(5, 9)] & 8'h7F) | 8'h80;
    @(negedge clk);
    addr = mkAddr(5, 9); drvData = d; drvEn = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1; drvEn = 1'b0;
    chk("R3 busy after strobe", busy, 1);
    model[mkAddr(5, 9)] = d;
    repeat (IDLE_CYC + COMMIT_CYC - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 busy before end", busy, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R6 busy after end", busy, 0);

    // R8, R9: polling status while busy
    lastByte = 8'h3C;
    writeByte(mkAddr(5, 10), lastByte);
    model[mkAddr(5, 10)] = lastByte;
    readByte(mkAddr(5, 10), r1);
    readByte(mkAddr(5, 10), r2);
    chk("R8 bit7 polled", r1 & 8'hBF, expPollBits(lastByte));
    chk("R9 bit6 flips", r1[6] ^ r2[6], 1);
    chk("R8 second read", r2 & 8'hBF, expPollBits(lastByte));
    waitIdle();
    checkPage(5, "R4 after poll");

    // R5: other page during loading ignored
    d = ~model[mkAddr(3, 4)];
    writeByte(mkAddr(3, 4), d);
    model[mkAddr(3, 4)] = d;
    writeByte(mkAddr(5, 4), ~model[mkAddr(5, 4)]);
    waitIdle();
    readByte(mkAddr(5, 4), r1);
    chk("R5 other page kept", r1, model[mkAddr(5, 4)]);
    readByte(mkAddr(3, 4), r1);
    chk("R5 own page written", r1, model[mkAddr(3, 4)]);

    // R7: write during commit ignored
    d = 8'h5A;
    writeByte(mkAddr(3, 20), d);
    model[mkAddr(3, 20)] = d;
    repeat (IDLE_CYC + 6) @(negedge clk);
    chk("R7 in commit", busy, 1);
    writeByte(mkAddr(3, 20), 8'hA5);
    writeByte(mkAddr(3, 21), ~model[mkAddr(3, 21)]);
    waitIdle();
    readByte(mkAddr(3, 20), r1);
    chk("R7 byte kept", r1, model[mkAddr(3, 20)]);
    readByte(mkAddr(3, 21), r1);
    chk("R7 neighbour kept", r1, model[mkAddr(3, 21)]);
    readByte(mkAddr(3, 20), r1);
    chk("R7 no new cycle", busy, 0);

    // R10: last write to an offset wins
    writeByte(mkAddr(5, 33), 8'h11);
    writeByte(mkAddr(5, 33), 8'h99);
    model[mkAddr(5, 33)] = 8'h99;
    waitIdle();
    readByte(mkAddr(5, 33), r1);
    chk("R10 last wins", r1, 8'h99);

    // R4: random partial pages, unloaded bytes unchanged
    for (int it = 0; it < 6; it++) begin
      int page;
      int n;
      page = ($urandom % 2 == 0) ? 3 : 5;
      n = 1 + int'($urandom % 8);
      for (int k = 0; k < n; k++) begin
        int o;
        o = int'($urandom % 64);
        d = 8'($urandom);
        writeByte(mkAddr(page, o), d);
        model[mkAddr(page, o)] = d;
      end
      waitIdle();
      checkPage(page, "R4 partial page");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule